// File: doc/BRIEF.md
# Programmable Four-Channel Chip Select Generator

This block turns the upper bits of an external bus address into four separate chip-select lines. Each of these lines is set up through its own control register. A register sets whether the channel is on, which of sixteen equal upper-address blocks it answers to, and whether its output is active-high or active-low. It also sets how many wait cycles an access to that channel takes, whether the access uses slow-peripheral timing, and whether an auxiliary data strobe is produced during a slow access.

An access begins when `accStart` is sampled high while the block is idle. The address is decoded in that same cycle and the result is latched. The selected line is then held asserted for the whole access. `accReady` rises for exactly one cycle, in the final cycle of the access. In slow-peripheral mode the access is two cycles longer, so that the auxiliary strobe can start one cycle after the select and end one cycle before it. This gives slow devices their framing signals without external glue logic.

Top module: `chipSelectGen`

## Requirements
- R1: After reset every register is zero. Every select therefore sits at its inactive level, which is high for a zero polarity bit, and `accReady` and `auxStrobe` are low.
- R2: A write with `cfgWe` high loads `cfgData` into the register of channel `cfgIdx`. The register fields are: bit 0 enable, bit 1 polarity, bits 3:2 wait count, bits 7:4 range, bit 8 strobe enable, bit 9 slow mode.
- R3: An access whose address bits [15:12] equal the range field of an enabled channel asserts that channel's select from the cycle after `accStart` until the access ends. At all other times the select stays inactive.
- R4: A channel whose enable bit is 0 never asserts its select, even when its range field matches.
- R5: With polarity 1 the asserted level is high. With polarity 0 the asserted level is low and the inactive level is high.
- R6: When several enabled channels match the address, only the lowest-numbered one is asserted.
- R7: A native-mode access to a channel with wait count w lasts w+1 cycles. `accReady` is low for the first w cycles and high only in the last one.
- R8: A slow-mode access to a channel with wait count w lasts w+3 cycles, and `accReady` is high only in the last one.
- R9: `auxStrobe` is high from the second cycle to the second-last cycle of a slow-mode access, but only when that channel's strobe-enable bit is 1. It stays low at all other times, including during native-mode accesses.
- R10: An access that no enabled channel matches asserts no select and raises `accReady` for one cycle, in the cycle after `accStart`.
- R11: While an access is under way, `accStart` and `busAddr` are ignored. The access keeps its length and its channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 16 | Bus address, decoded on its top four bits |
| accStart | input | 1 | Starts an access when sampled while idle |
| cfgWe | input | 1 | Control register write enable |
| cfgIdx | input | 2 | Channel whose register is written |
| cfgData | input | 10 | Control register write data |
| csOut | output | 4 | Chip-select lines, one per channel |
| auxStrobe | output | 1 | Auxiliary data strobe for slow accesses |
| accReady | output | 1 | One-cycle end-of-access indication |

## Verification
The hardest case to reach from the ports is a `accStart` that stays high, while the address moves into another channel's range, throughout a long slow access. A correct design must ignore both changes. The bench holds the start line high and switches the address after the first cycle of a four-cycle access. It then checks, cycle by cycle, that the select, the strobe window and the single ready pulse all belong to the channel latched at the start. Overlapping ranges are arranged so that priority and the disabled channel are both tested with the same address.

// File: rtl/csg_pkg.sv
package csg_pkg;
  localparam int RANGE_W = 4;
  localparam int WAIT_W  = 2;
  localparam int CFG_W   = RANGE_W + WAIT_W + 4;

  // control register layout, msb first: slow, strobe enable, range, wait, polarity, enable
  typedef struct packed {
    logic               slowMode;
    logic               strobeEn;
    logic [RANGE_W-1:0] rangeSel;
    logic [WAIT_W-1:0]  waitCnt;
    logic               polHigh;
    logic               enable;
  } chanCfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic busy;
    logic auxOn;
  } ctlStrobe_t;
endpackage

// File: rtl/csgDatapath.sv
module csgDatapath
  import csg_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  chanCfg_t          cfgData,
  input  logic [ADDR_W-1:0] busAddr,
  input  ctlStrobe_t        ctl,
  output logic              hitValid,
  output logic [WAIT_W-1:0] hitWait,
  output logic              hitSlow,
  output logic              hitStrb,
  output logic [NUM_CH-1:0] csOut
);
  chanCfg_t          cfgQ [NUM_CH];
  logic [IDX_W-1:0]  hitIdx;
  logic [IDX_W-1:0]  selIdxQ;
  logic              selValidQ;
  logic [NUM_CH-1:0] selOn;
  logic [NUM_CH-1:0] polVec;
  logic [RANGE_W-1:0] addrTop;

  assign addrTop = busAddr[ADDR_W-1 -: RANGE_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CH; i++) cfgQ[i] <= '0;
    end else if (cfgWe) begin
      cfgQ[cfgIdx] <= cfgData;
    end
  end

  // priority decode: lowest index wins, so scan from the top down
  always_comb begin
    hitValid = 1'b0;
    hitIdx   = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (cfgQ[i].enable && (cfgQ[i].rangeSel == addrTop)) begin
        hitValid = 1'b1;
        hitIdx   = IDX_W'(i);
      end
    end
  end

  assign hitWait = cfgQ[hitIdx].waitCnt;
  assign hitSlow = cfgQ[hitIdx].slowMode;
  assign hitStrb = cfgQ[hitIdx].strobeEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selIdxQ   <= '0;
      selValidQ <= 1'b0;
    end else if (ctl.capture) begin
      selIdxQ   <= hitIdx;
      selValidQ <= hitValid;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    assign selOn[g]  = ctl.busy && selValidQ && (selIdxQ == IDX_W'(g));
    assign polVec[g] = cfgQ[g].polHigh;
    assign csOut[g]  = cfgQ[g].polHigh ? selOn[g] : ~selOn[g];
  end

  // R3: outside an access every line sits at its inactive level
  p_idle_inactive_r3: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.busy |-> (csOut == ~polVec));

  // R6: never more than one line at its active level
  p_one_select_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~(csOut ^ polVec)));

  // R4: a captured hit always refers to a channel that was enabled at capture
  p_hit_enabled_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capture && hitValid) |-> cfgQ[hitIdx].enable);
endmodule

// File: rtl/csgControl.sv
module csgControl
  import csg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              accStart,
  input  logic              hitValid,
  input  logic [WAIT_W-1:0] hitWait,
  input  logic              hitSlow,
  input  logic              hitStrb,
  output ctlStrobe_t        ctl,
  output logic              accReady
);
  localparam int CNT_W = WAIT_W + 1;

  logic             busyQ;
  logic             firstQ;
  logic             auxEnQ;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] startCnt;

  assign startCnt = !hitValid ? '0
                  : (CNT_W'(hitWait) + (hitSlow ? CNT_W'(2) : CNT_W'(0)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      firstQ <= 1'b0;
      auxEnQ <= 1'b0;
      cntQ   <= '0;
    end else if (!busyQ) begin
      if (accStart) begin
        busyQ  <= 1'b1;
        firstQ <= 1'b1;
        auxEnQ <= hitValid && hitSlow && hitStrb;
        cntQ   <= startCnt;
      end
    end else begin
      firstQ <= 1'b0;
      if (cntQ == '0) busyQ <= 1'b0;
      else            cntQ  <= cntQ - 1'b1;
    end
  end

  assign ctl.capture = !busyQ && accStart;
  assign ctl.busy    = busyQ;
  assign ctl.auxOn   = busyQ && auxEnQ && !firstQ && (cntQ != '0);
  assign accReady    = busyQ && (cntQ == '0);

  // R7: ready is a single-cycle pulse
  p_ready_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    accReady |=> !accReady);

  // R9: strobe only after the access has already been running a cycle
  p_aux_late_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.auxOn |-> $past(busyQ));

  // R9: strobe ends while the select is still held
  p_aux_early_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.auxOn |=> busyQ);

  // R11: an access in progress runs until its ready cycle
  p_hold_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !accReady) |=> busyQ);
endmodule

// File: rtl/chipSelectGen.sv
module chipSelectGen
  import csg_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              accStart,
  input  logic              cfgWe,
  input  logic [$clog2(NUM_CH)-1:0] cfgIdx,
  input  logic [CFG_W-1:0]  cfgData,
  output logic [NUM_CH-1:0] csOut,
  output logic              auxStrobe,
  output logic              accReady
);
  localparam int IDX_W = $clog2(NUM_CH);

  ctlStrobe_t        ctl;
  logic              hitValid;
  logic [WAIT_W-1:0] hitWait;
  logic              hitSlow;
  logic              hitStrb;

  csgDatapath #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .cfgIdx   (cfgIdx),
    .cfgData  (chanCfg_t'(cfgData)),
    .busAddr  (busAddr),
    .ctl      (ctl),
    .hitValid (hitValid),
    .hitWait  (hitWait),
    .hitSlow  (hitSlow),
    .hitStrb  (hitStrb),
    .csOut    (csOut)
  );

  csgControl i_control (
    .clk      (clk),
    .rstN     (rstN),
    .accStart (accStart),
    .hitValid (hitValid),
    .hitWait  (hitWait),
    .hitSlow  (hitSlow),
    .hitStrb  (hitStrb),
    .ctl      (ctl),
    .accReady (accReady)
  );

  assign auxStrobe = ctl.auxOn;
endmodule

// File: tb/test_chipSelectGen.sv
`timescale 1ns/1ps
module test_chipSelectGen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic        accStart = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgIdx = '0;
  logic [9:0]  cfgData = '0;
  logic [3:0]  csOut;
  logic        auxStrobe;
  logic        accReady;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [3:0] polM = 4'b0000;

  always #4 clk = ~clk;
  always @(posedge clk) cycles++;

  chipSelectGen i_chipSelectGen (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .accStart(accStart),
    .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgData(cfgData),
    .csOut(csOut), .auxStrobe(auxStrobe), .accReady(accReady)
  );

  // field layout per R2
  function automatic logic [9:0] mk(bit slow, bit strb, logic [3:0] rng,
                                    logic [1:0] w, bit pol, bit en);
    return {slow, strb, rng, w, pol, en};
  endfunction

  typedef struct packed {
    logic [15:0] addr;
    logic [2:0]  ch;    // 4 means no channel
    logic [3:0]  len;
    logic        strb;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{16'h2ABC, 3'd0, 4'd1, 1'b0},   // R3 R5: ch0 active-low, no waits
    '{16'h5000, 3'd1, 4'd4, 1'b0},   // R6 R7: ch1 beats ch2, 3 waits, native (strobe off)
    '{16'h9123, 3'd4, 4'd1, 1'b0},   // R4 R10: ch3 disabled
    '{16'hF000, 3'd4, 4'd1, 1'b0},   // R10: no range match
    '{16'h2000, 3'd0, 4'd1, 1'b0}    // R3: repeat ch0
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeCfg(int idx, logic [9:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgIdx = 2'(idx); cfgData = d;
    polM[idx] = d[1];
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  function automatic logic [3:0] expCs(int ch, bit on);
    logic [3:0] v = ~polM;
    if (on && ch < 4) v[ch] = polM[ch];
    return v;
  endfunction

  // one access; holdStart keeps accStart high and moves the address to altAddr
  task automatic runAccess(string req, logic [15:0] addr, int ch, int len,
                           bit strb, bit holdStart, logic [15:0] altAddr);
    @(negedge clk);
    busAddr = addr; accStart = 1'b1;
    @(negedge clk);
    if (!holdStart) accStart = 1'b0;
    for (int k = 0; k < len; k++) begin
      check({req, " cs"}, 32'(csOut), 32'(expCs(ch, 1'b1)));
      check({req, " ready"}, 32'(accReady), 32'(k == len - 1));
      check({req, " strobe"}, 32'(auxStrobe), 32'(strb && k >= 1 && k <= len - 2));
      if (holdStart) busAddr = altAddr;
      if (k == len - 1) accStart = 1'b0;
      @(negedge clk);
    end
    check({req, " idle cs"}, 32'(csOut), 32'(expCs(ch, 1'b0)));
    check({req, " idle ready"}, 32'(accReady), 32'(0));
  endtask

  initial begin
    wait (cycles > 50000);
    bad++; total++;
    $display("FAIL watchdog R1..all actual=%0d expected<50000", cycles);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset levels
    check("R1 reset cs", 32'(csOut), 32'(4'hF));
    check("R1 reset ready", 32'(accReady), 32'(0));
    check("R1 reset strobe", 32'(auxStrobe), 32'(0));
    rstN = 1'b1;
    @(negedge clk);
    // R1: all channels disabled, nothing answers
    runAccess("R1 disabled after reset", 16'h0000, 4, 1, 1'b0, 1'b0, 16'h0);

    // R2 programming
    writeCfg(0, mk(0, 0, 4'h2, 2'd0, 0, 1));
    writeCfg(1, mk(0, 1, 4'h5, 2'd3, 1, 1));
    writeCfg(2, mk(1, 1, 4'h5, 2'd1, 1, 1));
    writeCfg(3, mk(0, 0, 4'h9, 2'd0, 1, 0));
    check("R2 R5 idle levels", 32'(csOut), 32'(4'b0001));

    for (int v = 0; v < 5; v++)
      runAccess("R2-R7 vector", VEC[v].addr, int'(VEC[v].ch), int'(VEC[v].len),
                VEC[v].strb, 1'b0, 16'h0);

    // R8 R9: disable ch1, ch2 slow with strobe, wait 1 -> 4 cycles
    writeCfg(1, mk(0, 1, 4'h5, 2'd3, 1, 0));
    runAccess("R8 R9 slow strobe", 16'h5555, 2, 4, 1'b1, 1'b0, 16'h0);

    // R9: slow mode without strobe enable
    writeCfg(2, mk(1, 0, 4'h5, 2'd1, 1, 1));
    runAccess("R9 strobe disabled", 16'h5555, 2, 4, 1'b0, 1'b0, 16'h0);

    // R8: slow, wait 3 -> 6 cycles, active-low
    writeCfg(3, mk(1, 1, 4'h9, 2'd3, 0, 1));
    runAccess("R8 long slow", 16'h9FFF, 3, 6, 1'b1, 1'b0, 16'h0);

    // R5: flip ch0 to active-high
    writeCfg(0, mk(0, 0, 4'h2, 2'd2, 1, 1));
    check("R5 polarity idle", 32'(csOut), 32'(4'b1000));
    runAccess("R5 R7 active-high wait2", 16'h2001, 0, 3, 1'b0, 1'b0, 16'h0);

    // R11: hold start high, move address into ch0 range mid-access
    writeCfg(2, mk(1, 1, 4'h5, 2'd1, 1, 1));
    runAccess("R11 start held", 16'h5000, 2, 4, 1'b1, 1'b1, 16'h2000);

    // R4: disable ch0 while its range is presented
    writeCfg(0, mk(0, 0, 4'h2, 2'd2, 1, 0));
    runAccess("R4 R10 disabled ch0", 16'h2222, 4, 1, 1'b0, 1'b0, 16'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule